// File: doc/BRIEF.md
# Configurable LFSR Test Pattern Generator

A Fibonacci-style linear feedback shift register that produces a stream of pseudo-random words for use as test vectors. Each advance shifts the register one place toward bit 0. The new bit enters at the top position and is the parity of the register bits selected by a tap mask parameter. A runtime mode input chooses plain parity (XOR) or inverted parity (XNOR) feedback. A seed can be loaded at any cycle. A lock-up flag reports when the register holds the one word that the current mode can never leave.

The tap mask must include bit 0 and must select an even number of bits. For width 3 the mask `3'b011` gives a 7-word cycle. For width 7 the masks `7'b1110001`, `7'b0011101` and `7'b0101011` each give a different 127-word cycle. Internally the register always runs XOR feedback. In XNOR mode the output is the bitwise complement of the internal state. Because the tap count is even, the complemented stream is exactly the XNOR-feedback stream.

Top module: `lfsr_gen`

## Requirements
- R1: While rst_ni is low, word_o reads all ones with xnor_i=0 and all zeros with xnor_i=1, and lock_err_o is 0.
- R2: In XOR mode (xnor_i=0), an advance makes the new word {fb, old[W-1:1]}, where fb is the XOR of the old bits selected by TAP_MASK. With W=3 and mask 3'b011, the words after seed 7 are 7,3,1,4,2,5,6 and then 7 again.
- R3: In XNOR mode (xnor_i=1), fb is the inverted XOR of the selected bits. With W=3 and mask 3'b011, the words after seed 0 are 0,4,6,3,5,2,1 and then 0 again.
- R4: With W=7, each of the masks 7'b1110001, 7'b0011101 and 7'b0101011 returns to the seed after exactly 127 advances. All 127 words are distinct and non-zero, and the three sequences differ from each other.
- R5: In XOR mode, a loaded all-zeros word stays all zeros under advance, with lock_err_o high.
- R6: In XNOR mode, a loaded all-ones word stays all ones under advance, with lock_err_o high.
- R7: lock_err_o is 1 exactly when word_o is the forbidden word of the current mode (all zeros for XOR, all ones for XNOR), in the same cycle as that word.
- R8: With load_i=0 and adv_i=0, word_o does not change across a clock edge.
- R9: When load_i=1 at an edge, word_o equals seed_i after that edge, whatever adv_i is.
- R10: Changing xnor_i complements word_o at once, with no clock edge. Later advances follow the new mode's sequence.
- R11: A different non-forbidden seed starts the same cycle at a different point. For example, seed 5 in XOR mode at W=3 gives 5,6,7,3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed load strobe, has priority over advance |
| seed_i | input | WIDTH | Seed word, as it will appear on word_o |
| adv_i | input | 1 | Advance the register one step |
| xnor_i | input | 1 | 0: XOR feedback, 1: XNOR feedback |
| word_o | output | WIDTH | Current register word |
| lock_err_o | output | 1 | Register holds the forbidden word for the mode |

## Verification
Loads and advances show on word_o one cycle after the edge that samples them, since there is one register in the path. lock_err_o and mode changes are combinational from that register and xnor_i, so they are valid in the same cycle. The bench drives inputs just after a falling edge and samples at the next falling edge, half a period after the rising edge that took effect. Mode flips are checked after a short delay with no edge in between.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic {
    FB_XOR  = 1'b0,
    FB_XNOR = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/lfsr_fb.sv
module lfsr_fb #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b011
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             fb_o
);
  logic [WIDTH:0] par;
  assign par[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign par[i+1] = par[i] ^ q_i[i];
    end else begin : g_off
      assign par[i+1] = par[i];
    end
  end
  assign fb_o = par[WIDTH];
endmodule

// File: rtl/lfsr_zero_det.sv
module lfsr_zero_det #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             zero_o
);
  logic [WIDTH:0] any;
  assign any[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_or
    assign any[i+1] = any[i] | q_i[i];
  end
  assign zero_o = ~any[WIDTH];
endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             adv_i,
  input  logic             xnor_i,
  output logic [WIDTH-1:0] word_o,
  output logic             lock_err_o
);
  import lfsr_pkg::*;

  localparam logic [WIDTH-1:0] RST_STATE = '1;

  fb_mode_e        mode;
  logic [WIDTH-1:0] inv_w;
  logic [WIDTH-1:0] q_r, q_nxt;
  logic             fb;
  logic             q_zero;

  assign mode  = fb_mode_e'(xnor_i);
  // XNOR stream is the complement of the XOR stream (even tap count)
  assign inv_w = {WIDTH{mode == FB_XNOR}};

  lfsr_fb #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) fb_i (
    .q_i (q_r),
    .fb_o(fb)
  );

  lfsr_zero_det #(.WIDTH(WIDTH)) zdet_i (
    .q_i   (q_r),
    .zero_o(q_zero)
  );

  always_comb begin
    q_nxt = q_r;
    if (load_i)     q_nxt = seed_i ^ inv_w;
    else if (adv_i) q_nxt = {fb, q_r[WIDTH-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= RST_STATE;
    else         q_r <= q_nxt;
  end

  assign word_o     = q_r ^ inv_w;
  assign lock_err_o = q_zero;
endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int unsigned WIDTH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [WIDTH-1:0] seed_i,
  input logic             adv_i,
  input logic             xnor_i,
  input logic [WIDTH-1:0] word_o,
  input logic             lock_err_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(word_o) || (xnor_i != $past(xnor_i))));

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ((word_o == $past(seed_i)) || (xnor_i != $past(xnor_i))));

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=>
      ((word_o[WIDTH-2:0] == $past(word_o[WIDTH-1:1])) || (xnor_i != $past(xnor_i))));

  assert_lock_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o == (xnor_i ? (&word_o) : (~|word_o)));

  assert_lock_stick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_err_o && !load_i) |=> lock_err_o);
endmodule

bind lfsr_gen lfsr_gen_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .seed_i    (seed_i),
  .adv_i     (adv_i),
  .xnor_i    (xnor_i),
  .word_o    (word_o),
  .lock_err_o(lock_err_o)
);

// File: tb/lfsr_gen_tb_top.sv
`timescale 1ns/100ps
module lfsr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       load3 = 0, adv3 = 0, xn3 = 0;
  logic [2:0] seed3 = '0;
  logic [2:0] word3;
  logic       lock3;

  logic       load7 = 0, adv7 = 0, xn7 = 0;
  logic [6:0] seed7 = '0;
  logic [6:0] wa, wb, wc;
  logic       la, lb, lc;

  localparam logic [6:0] MA = 7'b1110001;
  localparam logic [6:0] MB = 7'b0011101;
  localparam logic [6:0] MC = 7'b0101011;

  lfsr_gen #(.WIDTH(3), .TAP_MASK(3'b011)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load3), .seed_i(seed3), .adv_i(adv3),
    .xnor_i(xn3), .word_o(word3), .lock_err_o(lock3));
  lfsr_gen #(.WIDTH(7), .TAP_MASK(MA)) dut7_a_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load7), .seed_i(seed7), .adv_i(adv7),
    .xnor_i(xn7), .word_o(wa), .lock_err_o(la));
  lfsr_gen #(.WIDTH(7), .TAP_MASK(MB)) dut7_b_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load7), .seed_i(seed7), .adv_i(adv7),
    .xnor_i(xn7), .word_o(wb), .lock_err_o(lb));
  lfsr_gen #(.WIDTH(7), .TAP_MASK(MC)) dut7_c_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load7), .seed_i(seed7), .adv_i(adv7),
    .xnor_i(xn7), .word_o(wc), .lock_err_o(lc));

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] mdl_next(logic [6:0] w, logic [6:0] mask, int n, logic xn);
    logic [6:0] r;
    r = w >> 1;
    r[n-1] = (^(w & mask)) ^ xn;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load3_seed(input logic [2:0] s);
    load3 = 1; seed3 = s; step(); load3 = 0;
  endtask

  task automatic t_reset();
    xn3 = 0; #1;
    chk(word3 == 3'd7, "R1 word xor", word3, 7);
    chk(lock3 == 1'b0, "R1 lock xor", lock3, 0);
    xn3 = 1; #1;
    chk(word3 == 3'd0, "R1 word xnor", word3, 0);
    chk(lock3 == 1'b0, "R1 lock xnor", lock3, 0);
    xn3 = 0;
    @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_seq(input logic xn, input logic [2:0] s, input string tag);
    logic [6:0] e;
    xn3 = xn; load3_seed(s);
    e = {4'd0, s};
    chk(word3 == e[2:0], tag, word3, e);
    adv3 = 1;
    for (int i = 0; i < 8; i++) begin
      e = mdl_next(e, 7'b0000011, 3, xn);
      step();
      chk(word3 == e[2:0], tag, word3, e);
      chk(lock3 == 1'b0, "R7 no lock in cycle", lock3, 0);
    end
    adv3 = 0;
  endtask

  task automatic t_seq3_fixed();
    int exp_x[8] = '{7, 3, 1, 4, 2, 5, 6, 7};
    int exp_n[8] = '{0, 4, 6, 3, 5, 2, 1, 0};
    xn3 = 0; load3_seed(3'd7);
    adv3 = 1;
    for (int i = 0; i < 8; i++) begin
      chk(word3 == exp_x[i][2:0], "R2 fixed xor sequence", word3, exp_x[i]);
      step();
    end
    adv3 = 0;
    xn3 = 1; load3_seed(3'd0);
    adv3 = 1;
    for (int i = 0; i < 8; i++) begin
      chk(word3 == exp_n[i][2:0], "R3 fixed xnor sequence", word3, exp_n[i]);
      step();
    end
    adv3 = 0; xn3 = 0;
  endtask

  task automatic t_seed_rotate();
    int exp_r[4] = '{5, 6, 7, 3};
    xn3 = 0; load3_seed(3'd5);
    adv3 = 1;
    for (int i = 0; i < 4; i++) begin
      chk(word3 == exp_r[i][2:0], "R11 seed rotation", word3, exp_r[i]);
      step();
    end
    adv3 = 0;
  endtask

  task automatic t_lock();
    xn3 = 0; load3_seed(3'd0);
    chk(lock3 == 1'b1, "R5 lock flag xor", lock3, 1);
    adv3 = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(word3 == 3'd0, "R5 stuck zero", word3, 0);
      chk(lock3 == 1'b1, "R5 lock stays", lock3, 1);
    end
    adv3 = 0;
    xn3 = 1; load3_seed(3'd7);
    chk(lock3 == 1'b1, "R6 lock flag xnor", lock3, 1);
    adv3 = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(word3 == 3'd7, "R6 stuck ones", word3, 7);
      chk(lock3 == 1'b1, "R6 lock stays", lock3, 1);
    end
    adv3 = 0;
    load3_seed(3'd0);
    chk(lock3 == 1'b0, "R7 zero not forbidden in xnor", lock3, 0);
    xn3 = 0;
  endtask

  task automatic t_hold_prio();
    xn3 = 0; load3_seed(3'd4);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(word3 == 3'd4, "R8 hold", word3, 4);
    end
    adv3 = 1; load3 = 1; seed3 = 3'd6;
    step();
    chk(word3 == 3'd6, "R9 load beats advance", word3, 6);
    seed3 = 3'd2;
    step();
    chk(word3 == 3'd2, "R9 back-to-back load", word3, 2);
    load3 = 0;
    step();
    chk(word3 == 3'd5, "R9 advance after load", word3, 5);
    adv3 = 0;
  endtask

  task automatic t_mode_flip();
    xn3 = 0; load3_seed(3'd3);
    xn3 = 1; #1;
    chk(word3 == 3'd4, "R10 flip complements", word3, 4);
    @(negedge clk);
    adv3 = 1; step(); adv3 = 0;
    chk(word3 == 3'd6, "R10 xnor step after flip", word3, 6);
    xn3 = 0; #1;
    chk(word3 == 3'd1, "R10 flip back", word3, 1);
    @(negedge clk);
  endtask

  task automatic t_period7();
    bit seen_a[128], seen_b[128], seen_c[128];
    logic [6:0] ea, eb, ec;
    int diff_ab = 0, diff_ac = 0, diff_bc = 0, bad = 0, dup = 0;
    int per_a = 0, per_b = 0, per_c = 0;
    xn7 = 0; load7 = 1; seed7 = 7'd1; step(); load7 = 0;
    ea = 7'd1; eb = 7'd1; ec = 7'd1;
    adv7 = 1;
    for (int i = 1; i <= 127; i++) begin
      if (seen_a[wa] || wa == 0) dup++;
      if (seen_b[wb] || wb == 0) dup++;
      if (seen_c[wc] || wc == 0) dup++;
      seen_a[wa] = 1; seen_b[wb] = 1; seen_c[wc] = 1;
      step();
      ea = mdl_next(ea, MA, 7, 0);
      eb = mdl_next(eb, MB, 7, 0);
      ec = mdl_next(ec, MC, 7, 0);
      if (wa != ea || wb != eb || wc != ec) bad++;
      if (wa != wb) diff_ab++;
      if (wa != wc) diff_ac++;
      if (wb != wc) diff_bc++;
      if (per_a == 0 && wa == 7'd1) per_a = i;
      if (per_b == 0 && wb == 7'd1) per_b = i;
      if (per_c == 0 && wc == 7'd1) per_c = i;
    end
    adv7 = 0;
    chk(bad == 0, "R4 words match model", bad, 0);
    chk(dup == 0, "R4 distinct non-zero words", dup, 0);
    chk(per_a == 127, "R4 period mask a", per_a, 127);
    chk(per_b == 127, "R4 period mask b", per_b, 127);
    chk(per_c == 127, "R4 period mask c", per_c, 127);
    chk(diff_ab > 0 && diff_ac > 0 && diff_bc > 0, "R4 sequences differ",
        diff_ab * diff_ac * diff_bc, 1);
    xn7 = 1; load7 = 1; seed7 = 7'h7f; step(); load7 = 0;
    adv7 = 1; step(); adv7 = 0;
    chk(wa == 7'h7f && la, "R6 7-bit stuck ones", wa, 127);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_seq3_fixed();
    t_seq(1'b0, 3'd7, "R2 model xor");
    t_seq(1'b1, 3'd0, "R3 model xnor");
    t_seed_rotate();
    t_lock();
    t_hold_prio();
    t_mode_flip();
    t_period7();
    finish_run();
  end
endmodule